// File: doc/BRIEF.md
# Frequency-Acquisition and Lock-Steering Logic for a Split Phase-Frequency Detector

This block is the digital frequency-acquisition half of a phase-frequency detector. The phase path is only a pair of D flip-flops, one clocked by reference edges and one by divided-oscillator edges, and it is kept separate. The block watches both edge streams in a fast sampling clock domain. It reports whether the divided oscillator runs fast or slow relative to the reference, and reports lock. While the loop is pulling in, it drives two steering lines that force the phase flip-flops to push the oscillator in the needed direction. Once lock is reached the steering lines go quiet, so the phase path sees no activity from this logic and its gain is unchanged.

Two engines share the edge events. The coarse detector is a state machine with states `ACQ_SEARCH`, `ACQ_SLOW`, `ACQ_FAST` and `ACQ_LOCK`. Its transitions are: repeated reference edge to `ACQ_SLOW`, repeated oscillator edge to `ACQ_FAST`, and a run of alternating edges reaching the lock count to `ACQ_LOCK`. A repeated edge while in `ACQ_LOCK` moves it out to `ACQ_SLOW` or `ACQ_FAST`. The quadrant follower keeps a small phase counter that reference edges advance and oscillator edges retreat. Its slip state (`SLIP_NONE`, `SLIP_UP`, `SLIP_DN`) records the last cycle slip: a step past the top quadrant goes to `SLIP_UP`, a step below zero goes to `SLIP_DN`, and lock returns it to `SLIP_NONE`.

Top module: `pfd_acq_steer`

## Requirements
- R1: A synchronous active-high reset sets every output low. It also clears the last-edge memory, the alternation count, the slip state, and sets the quadrant to 2.
- R2: Each input goes through a two-stage synchroniser and a rising-edge detector. A rising input counts as exactly one event, and the outputs reflect it after the third rising clock edge that samples the input high.
- R3: A reference event that follows another reference event, with no oscillator event between, sets `vco_slow` high and `vco_fast` low.
- R4: An oscillator event that follows another oscillator event, with no reference event between, sets `vco_fast` high and `vco_slow` low.
- R5: Each event whose source differs from the previous event adds one to the alternation count, and a repeated event clears the count. When the count reaches LOCK_RUN (16 by default), `locked` goes high and both direction outputs go low. Until then, the current direction output holds.
- R6: A reference event and an oscillator event in the same clock cycle are ignored. State, quadrant, count and last-edge memory are all unchanged.
- R7: A repeated event while locked drops `locked` and raises the matching direction output.
- R8: A reference event advances the quadrant and an oscillator event retreats it. A reference event at quadrant 3 records an up-slip and re-centres to quadrant 2. An oscillator event at quadrant 0 records a down-slip and re-centres to quadrant 1. A new slip replaces the old one.
- R9: A recorded slip drives its steering line (up-slip gives `steer_up`, down-slip gives `steer_dn`) with priority over the coarse direction. With no slip recorded, `vco_slow` drives `steer_up` and `vco_fast` drives `steer_dn`. Both steering lines are low whenever `locked` is high, and at most one is ever high.
- R10: The first event after reset, with no previous event, only records its source. It raises no direction output and adds nothing to the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Reference edge stream (asynchronous) |
| vco_in | input | 1 | Divided-oscillator edge stream (asynchronous) |
| vco_fast | output | 1 | Divided oscillator judged faster than the reference |
| vco_slow | output | 1 | Divided oscillator judged slower than the reference |
| locked | output | 1 | Alternation run complete, loop locked |
| steer_up | output | 1 | Override forcing the phase path to pump up |
| steer_dn | output | 1 | Override forcing the phase path to pump down |

## Verification
Every result is due on the third rising clock edge after an input is first sampled high. Two edges come from the synchroniser, and one from the state and slip registers, which feed the outputs through gates only. The bench drives inputs on falling edges, holds each pulse one cycle, and then waits three further falling edges, so each check samples after that third rising edge. One directed test samples both one edge early and exactly on time to pin the latency. A mid-run reset checks that clearing takes effect by the next falling edge.

// File: rtl/acq_pkg.sv
package acq_pkg;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_REF,
        SRC_VCO
    } edge_src_t;

    typedef enum logic [1:0] {
        ACQ_SEARCH,
        ACQ_SLOW,
        ACQ_FAST,
        ACQ_LOCK
    } acq_state_t;

    typedef enum logic [1:0] {
        SLIP_NONE,
        SLIP_UP,
        SLIP_DN
    } slip_t;

endpackage

// File: rtl/acq_edge_sync.sv
module acq_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    output logic pulse
);
    // chain[STAGES-1] is the synchronised level, chain[STAGES] its previous value
    logic [STAGES:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-1:0], din};
    end

    always_comb pulse = chain[STAGES-1] & ~chain[STAGES];

    a_r2_one_cycle_pulse: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/acq_coarse_fsm.sv
module acq_coarse_fsm
    import acq_pkg::*;
#(
    parameter int LOCK_RUN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_p,
    input  logic vco_p,
    output logic vco_fast,
    output logic vco_slow,
    output logic locked
);
    localparam int CW = $clog2(LOCK_RUN + 1);
    localparam logic [CW-1:0] RUN_LAST = CW'(LOCK_RUN - 1);

    acq_state_t      state_q, state_d;
    edge_src_t       last_q, last_d;
    logic [CW-1:0]   run_q, run_d;
    logic            ev_ref, ev_vco, rep_ref, rep_vco, alt;

    always_comb begin
        ev_ref  = ref_p & ~vco_p;
        ev_vco  = vco_p & ~ref_p;
        rep_ref = ev_ref && (last_q == SRC_REF);
        rep_vco = ev_vco && (last_q == SRC_VCO);
        alt     = (ev_ref && (last_q == SRC_VCO)) || (ev_vco && (last_q == SRC_REF));
    end

    // next-state process
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        last_d  = last_q;
        if (ev_ref) last_d = SRC_REF;
        if (ev_vco) last_d = SRC_VCO;
        unique case (state_q)
            ACQ_SEARCH, ACQ_SLOW, ACQ_FAST: begin
                if (rep_ref) begin
                    state_d = ACQ_SLOW;
                    run_d   = '0;
                end else if (rep_vco) begin
                    state_d = ACQ_FAST;
                    run_d   = '0;
                end else if (alt) begin
                    if (run_q == RUN_LAST) begin
                        state_d = ACQ_LOCK;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + CW'(1);
                    end
                end
            end
            ACQ_LOCK: begin
                if (rep_ref) begin
                    state_d = ACQ_SLOW;
                    run_d   = '0;
                end else if (rep_vco) begin
                    state_d = ACQ_FAST;
                    run_d   = '0;
                end
            end
            default: state_d = ACQ_SEARCH;
        endcase
    end

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ACQ_SEARCH;
            last_q  <= SRC_NONE;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            last_q  <= last_d;
            run_q   <= run_d;
        end
    end

    // output process
    always_comb begin
        vco_fast = (state_q == ACQ_FAST);
        vco_slow = (state_q == ACQ_SLOW);
        locked   = (state_q == ACQ_LOCK);
    end

    a_r3_repeat_ref_slow: assert property (@(posedge clk) disable iff (rst)
        (ref_p && !vco_p && last_q == SRC_REF) |=> (vco_slow && !vco_fast));

    a_r4_repeat_vco_fast: assert property (@(posedge clk) disable iff (rst)
        (vco_p && !ref_p && last_q == SRC_VCO) |=> (vco_fast && !vco_slow));

    a_r6_both_ignored: assert property (@(posedge clk) disable iff (rst)
        (ref_p && vco_p) |=> ($stable(state_q) && $stable(last_q) && $stable(run_q)));

    a_r7_lock_exit: assert property (@(posedge clk) disable iff (rst)
        (locked && ((ref_p && !vco_p && last_q == SRC_REF) ||
                    (vco_p && !ref_p && last_q == SRC_VCO))) |=> !locked);

endmodule

// File: rtl/acq_quad_follow.sv
module acq_quad_follow
    import acq_pkg::*;
#(
    parameter int QW = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_p,
    input  logic vco_p,
    input  logic locked,
    output logic slip_up,
    output logic slip_dn
);
    localparam logic [QW-1:0] Q_TOP          = {QW{1'b1}};
    localparam logic [QW-1:0] Q_REF_RECENTRE = Q_TOP - QW'(1);
    localparam logic [QW-1:0] Q_VCO_RECENTRE = QW'(1);
    localparam logic [QW-1:0] Q_RESET        = Q_TOP - QW'(1);

    logic [QW-1:0] q_q, q_d;
    slip_t         slip_q, slip_d;
    logic          ev_ref, ev_vco;

    always_comb begin
        ev_ref = ref_p & ~vco_p;
        ev_vco = vco_p & ~ref_p;
    end

    // next-state process
    always_comb begin
        q_d    = q_q;
        slip_d = slip_q;
        if (locked) slip_d = SLIP_NONE;
        if (ev_ref) begin
            if (q_q == Q_TOP) begin
                q_d    = Q_REF_RECENTRE;
                slip_d = SLIP_UP;
            end else begin
                q_d = q_q + QW'(1);
            end
        end else if (ev_vco) begin
            if (q_q == '0) begin
                q_d    = Q_VCO_RECENTRE;
                slip_d = SLIP_DN;
            end else begin
                q_d = q_q - QW'(1);
            end
        end
    end

    // state register process
    always_ff @(posedge clk) begin
        if (rst) begin
            q_q    <= Q_RESET;
            slip_q <= SLIP_NONE;
        end else begin
            q_q    <= q_d;
            slip_q <= slip_d;
        end
    end

    // output process
    always_comb begin
        unique case (slip_q)
            SLIP_UP:   begin slip_up = 1'b1; slip_dn = 1'b0; end
            SLIP_DN:   begin slip_up = 1'b0; slip_dn = 1'b1; end
            default:   begin slip_up = 1'b0; slip_dn = 1'b0; end
        endcase
    end

    a_r8_ref_advance: assert property (@(posedge clk) disable iff (rst)
        (ref_p && !vco_p && q_q != Q_TOP) |=> (q_q == QW'($past(q_q) + QW'(1))));

    a_r8_ref_slip: assert property (@(posedge clk) disable iff (rst)
        (ref_p && !vco_p && q_q == Q_TOP) |=> (slip_up && q_q == Q_REF_RECENTRE));

    a_r8_vco_slip: assert property (@(posedge clk) disable iff (rst)
        (vco_p && !ref_p && q_q == '0) |=> (slip_dn && q_q == Q_VCO_RECENTRE));

    a_r6_quadrant_hold: assert property (@(posedge clk) disable iff (rst)
        (ref_p && vco_p) |=> $stable(q_q));

endmodule

// File: rtl/pfd_acq_steer.sv
module pfd_acq_steer #(
    parameter int SYNC_STAGES = 2,
    parameter int LOCK_RUN    = 16,
    parameter int QUAD_W      = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_in,
    input  logic vco_in,
    output logic vco_fast,
    output logic vco_slow,
    output logic locked,
    output logic steer_up,
    output logic steer_dn
);
    localparam int N_IN = 2;

    logic [N_IN-1:0] raw_in, ev_pulse;
    logic            slip_up, slip_dn;

    always_comb raw_in = {vco_in, ref_in};

    for (genvar g = 0; g < N_IN; g++) begin : g_sync
        acq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk  (clk),
            .rst  (rst),
            .din  (raw_in[g]),
            .pulse(ev_pulse[g])
        );
    end

    acq_coarse_fsm #(.LOCK_RUN(LOCK_RUN)) u_coarse (
        .clk     (clk),
        .rst     (rst),
        .ref_p   (ev_pulse[0]),
        .vco_p   (ev_pulse[1]),
        .vco_fast(vco_fast),
        .vco_slow(vco_slow),
        .locked  (locked)
    );

    acq_quad_follow #(.QW(QUAD_W)) u_follow (
        .clk    (clk),
        .rst    (rst),
        .ref_p  (ev_pulse[0]),
        .vco_p  (ev_pulse[1]),
        .locked (locked),
        .slip_up(slip_up),
        .slip_dn(slip_dn)
    );

    // steering: follower slip first, coarse direction second, silent in lock
    always_comb begin
        steer_up = !locked && (slip_up || (vco_slow && !slip_dn));
        steer_dn = !locked && (slip_dn || (vco_fast && !slip_up));
    end

    a_r1_reset_clears: assert property (@(posedge clk)
        rst |=> (!vco_fast && !vco_slow && !locked && !steer_up && !steer_dn));

    a_r9_quiet_in_lock: assert property (@(posedge clk) disable iff (rst)
        locked |-> (!steer_up && !steer_dn));

    a_r9_steer_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(steer_up && steer_dn));

    a_r5_lock_no_direction: assert property (@(posedge clk) disable iff (rst)
        $rose(locked) |-> (!vco_fast && !vco_slow));

endmodule

// File: tb/test_pfd_acq_steer.sv
module test_pfd_acq_steer;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_in = 1'b0;
    logic vco_in = 1'b0;
    logic vco_fast, vco_slow, locked, steer_up, steer_dn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pfd_acq_steer i_pfd_acq_steer (
        .clk     (clk),
        .rst     (rst),
        .ref_in  (ref_in),
        .vco_in  (vco_in),
        .vco_fast(vco_fast),
        .vco_slow(vco_slow),
        .locked  (locked),
        .steer_up(steer_up),
        .steer_dn(steer_dn)
    );

    // kinds: 0 reference edge, 1 oscillator edge, 2 oscillator-then-reference pair, 3 both at once
    // entry = {req[3:0], kind[1:0], reps[3:0], exp{fast,slow,lock,up,dn}}
    localparam int NV = 17;
    localparam logic [14:0] VEC [NV] = '{
        {4'd10, 2'd0, 4'd1, 5'b00000},  // R10 first edge only recorded
        {4'd3,  2'd0, 4'd1, 5'b01010},  // R3 repeated reference, slip up too
        {4'd5,  2'd2, 4'd7, 5'b01010},  // R5 alternation holds direction
        {4'd5,  2'd1, 4'd1, 5'b01010},  // R5 count 15
        {4'd5,  2'd0, 4'd1, 5'b00100},  // R5 count 16 -> lock, R9 quiet
        {4'd5,  2'd2, 4'd3, 5'b00100},  // R5 lock held
        {4'd6,  2'd3, 4'd1, 5'b00100},  // R6 simultaneous ignored
        {4'd7,  2'd0, 4'd1, 5'b01010},  // R7 repeat (last stayed reference) leaves lock
        {4'd5,  2'd1, 4'd1, 5'b01010},  // R5 alternating keeps slow
        {4'd4,  2'd1, 4'd1, 5'b10001},  // R4 repeated oscillator
        {4'd4,  2'd1, 4'd1, 5'b10001},  // R4
        {4'd8,  2'd1, 4'd1, 5'b10001},  // R8 down-slip at quadrant 0
        {4'd8,  2'd0, 4'd1, 5'b10001},  // R8 quadrant 1 -> 2
        {4'd9,  2'd0, 4'd1, 5'b01001},  // R9 slip down outranks coarse slow
        {4'd8,  2'd0, 4'd1, 5'b01010},  // R8 up-slip replaces down-slip
        {4'd5,  2'd2, 4'd8, 5'b00100},  // R5 relock after 16
        {4'd6,  2'd3, 4'd2, 5'b00100}   // R6 simultaneous ignored in lock
    };

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic check_out(input string tag, input logic [4:0] exp);
        logic [4:0] act;
        act = {vco_fast, vco_slow, locked, steer_up, steer_dn};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: {fast,slow,lock,up,dn} actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic apply_edge(input logic [1:0] kind);
        @(negedge clk);
        case (kind)
            2'd0: ref_in = 1'b1;
            2'd1: vco_in = 1'b1;
            default: begin ref_in = 1'b1; vco_in = 1'b1; end
        endcase
        @(negedge clk);
        ref_in = 1'b0;
        vco_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        check_out("R1 reset state", 5'b00000);

        // R2 latency: one reference edge, then a second one sampled early and on time
        apply_edge(2'd0);
        @(negedge clk);
        ref_in = 1'b1;
        @(negedge clk);
        ref_in = 1'b0;
        @(negedge clk);
        check_out("R2 not yet after two edges", 5'b00000);
        @(negedge clk);
        check_out("R2 due on third edge", 5'b01010);
        repeat (3) @(negedge clk);

        do_reset();
        for (int i = 0; i < NV; i++) begin
            logic [3:0] req;
            logic [1:0] kind;
            logic [3:0] reps;
            {req, kind, reps} = VEC[i][14:5];
            for (int k = 0; k < int'(reps); k++) begin
                if (kind == 2'd2) begin
                    apply_edge(2'd1);
                    apply_edge(2'd0);
                end else begin
                    apply_edge(kind);
                end
            end
            check_out($sformatf("R%0d vector %0d", req, i), VEC[i][4:0]);
        end

        // R1 reset while locked
        do_reset();
        check_out("R1 reset from lock", 5'b00000);
        apply_edge(2'd0);
        check_out("R10 first edge after reset", 5'b00000);
        apply_edge(2'd0);
        check_out("R3 repeat after reset", 5'b01010);

        finish_run();
    end

endmodule